// File: doc/BRIEF.md
# Pipelined Burst Static Memory with Late Write

This block is a synchronous data store for a processor cache. It registers every input on the rising clock edge. A strobe input opens a burst of up to four beats. After the opening beat, an advance input steps an internal two-bit address counter through the aligned four-word block. The burst may pause and resume.

Writes are late: the data for a write beat is taken one rising edge after that beat's address. Read beats return their word through a registered output three edges after the request is taken. An output-enable flag and a complementary strobe pair mark each returned beat.

A read that hits a word whose late-write data has not yet reached the array returns that pending data, so a read placed straight after a write sees the new value. The depth is set by `ADDR_W`, and the value 16 gives the full 65536-word store.

Top module: `pbsram_core`

## Requirements
- R1: The store holds 2^ADDR_W words of DATA_W (36) bits. Every address, including the highest, reads back the last value written to it.
- R2: On a rising edge where `burst_start` is high, the block takes `addr` and `wr_en` (1 = write, 0 = read) and performs the first beat of a new burst at `addr`.
- R3: On an edge where `burst_next` is high and the burst has beats left, the block performs a beat at the previous beat's address with bits [1:0] incremented modulo 4 and bits above bit 1 unchanged. An edge with `burst_next` low inserts no beat, and the burst resumes later.
- R4: A burst has at most four beats: the opening beat and three advances. Further `burst_next` edges neither write nor return data.
- R5: For a write beat taken on edge k, the word stored is the `wdata` value taken on edge k+1.
- R6: For a read beat taken on edge k, `rdata` holds the word and `rdata_oe` is high after edge k+3.
- R7: A read beat taken on the edge right after a write beat to the same address returns the data of that write.
- R8: In a cycle with no read beat being returned, `rdata_oe` is 0, `rdata` is 0, `strobe_p` is 0 and `strobe_n` is 1.
- R9: `strobe_p` is 1 on the first returned beat after an idle cycle. It inverts on each further consecutive beat, and `strobe_n` is always its complement.
- R10: Pulling `rst_n` low at once clears the outputs to their idle values and cancels the burst state, the pending write and the read pipeline. Release takes effect two edges later. After release, `burst_next` with no new `burst_start` has no effect.
- R11: A `burst_start` in the middle of a burst ends the old burst and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_start | input | 1 | Opens a burst at `addr` |
| burst_next | input | 1 | Advances the current burst by one beat |
| wr_en | input | 1 | Direction of the burst opened by `burst_start` (1 = write) |
| addr | input | ADDR_W | Start address of a burst |
| wdata | input | DATA_W | Late-write data, taken one edge after its beat |
| rdata | output | DATA_W | Registered read data, 0 when idle |
| rdata_oe | output | 1 | High while `rdata` carries a read beat |
| strobe_p | output | 1 | Data strobe, inverting with each returned beat |
| strobe_n | output | 1 | Complement of `strobe_p` |

## Verification
The bench writes a burst whose start address is not aligned and reads it back starting from another offset, with a pause. If the counter failed to wrap or the upper bits moved, wrong words or gaps in `rdata_oe` would appear in the latency slots. It sends a fifth advance carrying poison data and then reads the target word, so an unbounded burst shows up as corrupted data. Reads placed right after writes to the same word expose a missing bypass as stale data. A reset in the middle of a read, followed by bare advances, shows any leftover burst or pipeline state as output activity where none is allowed.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  localparam int CNT_W = 2;
  localparam int BURST_BEATS = 1 << CNT_W;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } beat_op_e;
endpackage

// File: rtl/pbsram_burst_ctl.sv
module pbsram_burst_ctl
  import pbsram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_start,
  input  logic          burst_next,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output beat_op_e      beat_op,
  output logic [AW-1:0] beat_addr
);
  localparam int HI_W = AW - CNT_W;

  logic             start_q, next_q, we_q;
  logic [AW-1:0]    addr_q;
  logic [HI_W-1:0]  base_q, base_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, left_q, left_d;
  logic             bwe_q, bwe_d;

  always_comb begin
    base_d    = base_q;
    cnt_d     = cnt_q;
    left_d    = left_q;
    bwe_d     = bwe_q;
    beat_op   = OP_NONE;
    beat_addr = addr_q;
    if (start_q) begin
      base_d    = addr_q[AW-1:CNT_W];
      cnt_d     = addr_q[CNT_W-1:0];
      left_d    = CNT_W'(BURST_BEATS - 1);
      bwe_d     = we_q;
      beat_op   = we_q ? OP_WRITE : OP_READ;
      beat_addr = addr_q;
    end else if (next_q && (left_q != '0)) begin
      cnt_d     = cnt_q + 1'b1;
      left_d    = left_q - 1'b1;
      beat_op   = bwe_q ? OP_WRITE : OP_READ;
      beat_addr = {base_q, cnt_d};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      next_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      left_q  <= '0;
      bwe_q   <= 1'b0;
    end else begin
      start_q <= burst_start;
      next_q  <= burst_next;
      we_q    <= wr_en;
      addr_q  <= addr;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
      bwe_q   <= bwe_d;
    end
  end

  // Checker state: beats since the last opening beat, and its upper bits.
  logic [2:0]      beats_chk;
  logic [HI_W-1:0] hi_chk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_chk <= '0;
      hi_chk    <= '0;
    end else if (beat_op != OP_NONE) begin
      if (start_q) begin
        beats_chk <= 3'd1;
        hi_chk    <= beat_addr[AW-1:CNT_W];
      end else begin
        beats_chk <= beats_chk + 3'd1;
      end
    end
  end

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beats_chk <= 3'd4);

  // R3
  burst_hi_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_op != OP_NONE && !start_q) |-> beat_addr[AW-1:CNT_W] == hi_chk);

  // R3
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_op != OP_NONE && !start_q && $past(beat_op != OP_NONE))
      |-> beat_addr[CNT_W-1:0] == $past(beat_addr[CNT_W-1:0]) + 2'd1);
endmodule

// File: rtl/pbsram_array.sv
module pbsram_array
  import pbsram_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  beat_op_e      beat_op,
  input  logic [AW-1:0] beat_addr,
  input  logic [DW-1:0] wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          pend_v_q, pend_v_d;
  logic [AW-1:0] pend_addr_q, pend_addr_d;
  logic [DW-1:0] wdat_q;
  logic          rd_v_q, rd_v_d;
  logic [DW-1:0] rd_data_q;
  logic          is_wr, is_rd, bypass;

  always_comb begin
    is_wr       = (beat_op == OP_WRITE);
    is_rd       = (beat_op == OP_READ);
    bypass      = pend_v_q && (pend_addr_q == beat_addr);
    pend_v_d    = is_wr;
    pend_addr_d = is_wr ? beat_addr : pend_addr_q;
    rd_v_d      = is_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      rd_v_q      <= 1'b0;
    end else begin
      pend_v_q    <= pend_v_d;
      pend_addr_q <= pend_addr_d;
      rd_v_q      <= rd_v_d;
    end
  end

  // Late data capture and array commit, each with its own enable.
  always_ff @(posedge clk) begin
    if (is_wr)    wdat_q <= wdata;
    if (pend_v_q) mem[pend_addr_q] <= wdat_q;
    if (is_rd)    rd_data_q <= bypass ? wdat_q : mem[beat_addr];
  end

  assign rd_valid = rd_v_q;
  assign rd_data  = rd_data_q;

  // R5
  pend_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && beat_op != OP_WRITE) |=> !pend_v_q);
endmodule

// File: rtl/pbsram_out_stage.sv
module pbsram_out_stage #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          strobe_p,
  output logic          strobe_n
);
  logic          c_v_q;
  logic [DW-1:0] c_d_q;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          oe_q, oe_d, sp_q, sp_d, sn_q, sn_d;

  always_comb begin
    oe_d    = c_v_q;
    rdata_d = c_v_q ? c_d_q : '0;
    sp_d    = c_v_q ? ~sp_q : 1'b0;
    sn_d    = c_v_q ? sp_q : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_v_q   <= 1'b0;
      c_d_q   <= '0;
      rdata_q <= '0;
      oe_q    <= 1'b0;
      sp_q    <= 1'b0;
      sn_q    <= 1'b1;
    end else begin
      c_v_q   <= rd_valid;
      if (rd_valid) c_d_q <= rd_data;
      rdata_q <= rdata_d;
      oe_q    <= oe_d;
      sp_q    <= sp_d;
      sn_q    <= sn_d;
    end
  end

  assign rdata    = rdata_q;
  assign rdata_oe = oe_q;
  assign strobe_p = sp_q;
  assign strobe_n = sn_q;

  // R8
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0 && !strobe_p && strobe_n));

  // R9
  strobe_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && $past(rdata_oe)) |-> strobe_p != $past(strobe_p));

  // R9
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n == !strobe_p);
endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
  import pbsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_start,
  input  logic              burst_next,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              strobe_p,
  output logic              strobe_n
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  beat_op_e            beat_op;
  logic [ADDR_W-1:0]   beat_addr;
  logic                rd_valid;
  logic [DATA_W-1:0]   rd_data;

  pbsram_burst_ctl #(.AW(ADDR_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .burst_start (burst_start),
    .burst_next  (burst_next),
    .wr_en       (wr_en),
    .addr        (addr),
    .beat_op     (beat_op),
    .beat_addr   (beat_addr)
  );

  pbsram_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .beat_op   (beat_op),
    .beat_addr (beat_addr),
    .wdata     (wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  pbsram_out_stage #(.DW(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .strobe_p (strobe_p),
    .strobe_n (strobe_n)
  );

  // R6
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (beat_op == OP_READ) |-> ##3 rdata_oe);
endmodule

// File: tb/pbsram_core_tb.sv
module pbsram_core_tb;
  localparam int AW = 10;
  localparam int DW = 36;
  localparam int NV = 22;
  localparam int NR = NV + 4;

  // {tag[3:0], start, next, wr, addr[9:0], data[35:0]}
  localparam logic [52:0] VEC [NV] = '{
    {4'd5,  1'b1, 1'b0, 1'b1, 10'h012, 36'h000000000},
    {4'd5,  1'b0, 1'b1, 1'b0, 10'h000, 36'hA00000012},
    {4'd5,  1'b0, 1'b1, 1'b0, 10'h000, 36'hA00000013},
    {4'd5,  1'b0, 1'b1, 1'b0, 10'h000, 36'hA00000010},
    {4'd4,  1'b0, 1'b1, 1'b0, 10'h000, 36'hA00000011},
    {4'd4,  1'b0, 1'b0, 1'b0, 10'h000, 36'h5DEADBEEF},
    {4'd2,  1'b1, 1'b0, 1'b0, 10'h013, 36'h000000000},
    {4'd3,  1'b0, 1'b1, 1'b0, 10'h000, 36'h000000000},
    {4'd3,  1'b0, 1'b0, 1'b0, 10'h000, 36'h000000000},
    {4'd3,  1'b0, 1'b1, 1'b0, 10'h000, 36'h000000000},
    {4'd3,  1'b0, 1'b1, 1'b0, 10'h000, 36'h000000000},
    {4'd4,  1'b0, 1'b1, 1'b0, 10'h000, 36'h000000000},
    {4'd5,  1'b1, 1'b0, 1'b1, 10'h020, 36'h000000000},
    {4'd7,  1'b1, 1'b0, 1'b0, 10'h020, 36'hB00000020},
    {4'd5,  1'b1, 1'b0, 1'b1, 10'h100, 36'h000000000},
    {4'd5,  1'b0, 1'b1, 1'b0, 10'h000, 36'hC00000100},
    {4'd7,  1'b1, 1'b0, 1'b0, 10'h101, 36'hC00000101},
    {4'd11, 1'b1, 1'b0, 1'b0, 10'h100, 36'h000000000},
    {4'd4,  1'b1, 1'b0, 1'b0, 10'h012, 36'h000000000},
    {4'd1,  1'b1, 1'b0, 1'b1, 10'h3FF, 36'h000000000},
    {4'd1,  1'b0, 1'b0, 1'b0, 10'h000, 36'hFFFFFFFFF},
    {4'd1,  1'b1, 1'b0, 1'b0, 10'h3FF, 36'h000000000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_start = 1'b0, burst_next = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe, strobe_p, strobe_n;

  always #10 clk = ~clk;

  pbsram_core #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .burst_next(burst_next),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .strobe_p(strobe_p), .strobe_n(strobe_n)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // Reference model, written from the requirements.
  logic [DW-1:0]   ref_mem [1 << AW];
  logic [AW-3:0]   m_base;
  logic [1:0]      m_cnt, m_left;
  logic            m_bwe, m_pw;
  logic [AW-1:0]   m_paddr;
  logic            exp_v [NR];
  logic [DW-1:0]   exp_d [NR];
  logic [3:0]      row_tag [NR];
  logic            exp_sp;

  function automatic string tag_str(input logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd7:  return "R7";
      4'd11: return "R11";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_row(input int i, input logic s, input logic a, input logic w,
                           input logic [AW-1:0] ad, input logic [DW-1:0] d);
    logic bv, bw;
    logic [AW-1:0] ba;
    if (m_pw) ref_mem[m_paddr] = d;
    bv = 1'b0; bw = 1'b0; ba = ad;
    if (s) begin
      bv = 1'b1; bw = w; ba = ad;
      m_base = ad[AW-1:2]; m_cnt = ad[1:0]; m_left = 2'd3; m_bwe = w;
    end else if (a && m_left != 2'd0) begin
      m_cnt = m_cnt + 2'd1; m_left = m_left - 2'd1;
      bv = 1'b1; bw = m_bwe; ba = {m_base, m_cnt};
    end
    exp_v[i] = bv && !bw;
    exp_d[i] = (bv && !bw) ? ref_mem[ba] : '0;
    m_pw = bv && bw;
    m_paddr = ba;
  endtask

  task automatic check_idle(input string req, input string what);
    check(!rdata_oe && rdata == '0, req, {what, " oe/data"}, {rdata_oe, rdata[DW-2:0]}, '0);
    check(!strobe_p && strobe_n, req, {what, " strobes"}, {strobe_p, strobe_n}, 2'b01);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [52:0] v;
    m_base = '0; m_cnt = '0; m_left = '0; m_bwe = 0; m_pw = 0; m_paddr = '0; exp_sp = 0;
    repeat (3) @(negedge clk);
    check_idle("R10", "in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R10", "after reset");

    // Vector walk: row j driven at negedge j, its result sampled at negedge j+4.
    for (int j = 0; j < NR; j++) begin
      @(negedge clk);
      if (j >= 4) begin
        int r;
        r = j - 4;
        check(rdata_oe == exp_v[r], exp_v[r] ? "R6" : "R8",
              $sformatf("row %0d oe", r), {35'd0, rdata_oe}, {35'd0, exp_v[r]});
        if (exp_v[r])
          check(rdata == exp_d[r], tag_str(row_tag[r]),
                $sformatf("row %0d data", r), rdata, exp_d[r]);
        exp_sp = exp_v[r] ? ~exp_sp : 1'b0;
        check(strobe_p == exp_sp && strobe_n == !exp_sp, "R9",
              $sformatf("row %0d strobes", r), {strobe_p, strobe_n}, {exp_sp, !exp_sp});
      end
      v = (j < NV) ? VEC[j] : '0;
      row_tag[j] = v[52:49];
      burst_start = v[48]; burst_next = v[47]; wr_en = v[46];
      addr = v[45:36]; wdata = v[35:0];
      model_row(j, v[48], v[47], v[46], v[45:36], v[35:0]);
    end

    // R10: reset in the middle of a read, then bare advances.
    @(negedge clk);
    burst_start = 1'b1; wr_en = 1'b0; addr = 10'h012; burst_next = 1'b0;
    @(negedge clk);
    burst_start = 1'b0;
    rst_n = 1'b0;
    #1 check_idle("R10", "async clear");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_idle("R10", "held reset");
    end
    rst_n = 1'b1;
    burst_next = 1'b1;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      check_idle("R10", "advance without start");
    end
    burst_next = 1'b0;
    burst_start = 1'b1; addr = 10'h013;
    @(negedge clk);
    burst_start = 1'b0;
    repeat (3) @(negedge clk);
    check(rdata_oe && rdata == 36'hA00000013, "R10", "read after reset",
          rdata, 36'hA00000013);
    @(negedge clk);
    check_idle("R8", "idle after single read");
    finish_run();
  end
endmodule